// File: doc/BRIEF.md
# Time-Multiplexed Spiking Neuron Updater

This block carries out the neuron-update half of a two-phase simulation tick, where one tick stands for one millisecond of model time. When `start` is accepted, it walks through every neuron in ascending index order and admits one neuron per cycle into a shared arithmetic pipeline. For each neuron it reads the packed state word (membrane potential v, recovery u and the parameters a, b, c, d) and the accumulated synaptic input current. It advances v and u by one forward-Euler step of the quadratic two-variable spiking model in signed Q8.8 fixed point and writes the result back.

The input-current word of each neuron is cleared as it is consumed, so that the next synaptic accumulation phase starts from zero. Every neuron that reaches the firing threshold is reset, and its index is pushed onto a valid/ready stream that feeds the following synapse phase. A small spike queue absorbs stalls on that stream. The block slows neuron admission rather than dropping a spike. `done` pulses once the last write-back has been issued.

Top module: `neuron_step_engine`

## Requirements
- R1: While reset is applied and after it, `done`, `spk_valid`, `st_rd_en`, `st_wr_en`, `cur_rd_en` and `cur_clr_en` are low until a pass is started.
- R2: A high `start` while idle begins a pass. Neurons are read in ascending index order from 0 to NUM_NEURONS-1, one read per cycle, unless the spike queue is backed up. A `start` during a pass is ignored.
- R3: The state word holds v in bits 15:0, u in 31:16, a in 47:32, b in 63:48, c in 79:64 and d in 95:80, all signed Q8.8. The candidate potential is v' = sat(v + ((((v·v)>>>8)·10)>>>8) + 5v + 35840 − u + I), where sat clamps to the range −32768..32767.
- R4: The candidate recovery is u' = sat(u + ((a·(((b·v)>>>8) − u))>>>8)). It uses the old v and the old u.
- R5: If v' ≥ 7680 (30.0), the neuron fires: the stored v becomes c and the stored u becomes sat(u' + d). Otherwise v' and u' are stored.
- R6: Each neuron's current word is read exactly once per pass. It is cleared to zero at the same address in the cycle after its read.
- R7: The indices of firing neurons appear on `spk_idx` in ascending order, each exactly once. A presented index stays valid and unchanged until `spk_ready` is high, and no spike is lost under backpressure.
- R8: `done` is high for exactly one cycle per pass. With `spk_ready` held high, it is seen at the (NUM_NEURONS+3)th rising edge after the edge that accepted `start`.
- R9: Every neuron is written back exactly once per pass, to the address it was read from, in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin one update pass (sampled while idle) |
| done | output | 1 | One-cycle pulse after the last write-back |
| st_rd_en | output | 1 | State memory read enable (data returns one cycle later) |
| st_rd_addr | output | AW | State memory read address |
| st_rd_data | input | 96 | State word read data |
| st_wr_en | output | 1 | State memory write enable |
| st_wr_addr | output | AW | State memory write address |
| st_wr_data | output | 96 | Updated state word |
| cur_rd_en | output | 1 | Current memory read enable (data returns one cycle later) |
| cur_rd_addr | output | AW | Current memory read address |
| cur_rd_data | input | 16 | Accumulated input current, Q8.8 |
| cur_clr_en | output | 1 | Write zero to the current memory |
| cur_clr_addr | output | AW | Address to clear |
| spk_valid | output | 1 | Spike index available |
| spk_ready | input | 1 | Consumer accepts the spike index |
| spk_idx | output | AW | Index of a firing neuron |

## Verification
The bench builds the block with NUM_NEURONS = 8 and FIFO_DEPTH = 4. With 8 neurons, every neuron can be given a distinct hand-picked state in one table, and the exact done latency of 11 edges is easy to check. It also allows a pass in which all eight neurons fire. A queue of four that is held stalled then fills within a single pass, which forces the admission throttle to act and checks that no spike is lost or reordered. Large input currents drive the potential into saturation, so the clamp in the update step is exercised as well.

// File: rtl/ne_pkg.sv
package ne_pkg;
  localparam int DW     = 16;
  localparam int FRAC   = 8;
  localparam int WW     = 48;
  localparam int K_SQ   = (4 * (1 << FRAC) + 50) / 100;
  localparam int K_LIN  = 5;
  localparam int C_BIAS = 140 << FRAC;
  localparam int V_PEAK = 30 << FRAC;
  localparam longint SAT_HI = (64'sd1 <<< (DW - 1)) - 1;
  localparam longint SAT_LO = -SAT_HI - 1;

  typedef struct packed {
    logic signed [DW-1:0] d;
    logic signed [DW-1:0] c;
    logic signed [DW-1:0] b;
    logic signed [DW-1:0] a;
    logic signed [DW-1:0] u;
    logic signed [DW-1:0] v;
  } nstate_t;

  localparam int SW = $bits(nstate_t);

  function automatic logic signed [DW-1:0] sat_q(input logic signed [WW-1:0] x);
    if (x > SAT_HI)      sat_q = DW'(SAT_HI);
    else if (x < SAT_LO) sat_q = DW'(SAT_LO);
    else                 sat_q = DW'(x);
  endfunction
endpackage

// File: rtl/spike_queue.sv
module spike_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 10,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_i,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count
);
  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wp, rp, wp_n, rp_n;
  logic [CW-1:0] cnt_n;
  logic          pop;

  assign pop       = out_valid && out_ready;
  assign out_valid = (count != '0);
  assign out_data  = slots[rp];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    bump = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_n  = push ? bump(wp) : wp;
    rp_n  = pop  ? bump(rp) : rp;
    cnt_n = count + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      wp    <= wp_n;
      rp    <= rp_n;
      count <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wp] <= push_data;
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_i)
    push |-> (count != CW'(DEPTH)) || pop);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_i)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/izh_update.sv
module izh_update
  import ne_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic                 clk,
  input  logic                 rst_i,
  input  logic                 in_v,
  input  logic [AW-1:0]        in_idx,
  input  logic [SW-1:0]        in_st,
  input  logic signed [DW-1:0] in_cur,
  output logic                 wb_v,
  output logic [AW-1:0]        wb_idx,
  output logic [SW-1:0]        wb_st,
  output logic                 wb_spike
);
  nstate_t                   st_in, r_st, st_out;
  logic signed [DW-1:0]      r_cur;
  logic signed [2*DW-1:0]    vv_n, bv_n, r_vv, r_bv;
  logic [AW-1:0]             r_idx;
  logic                      r_v;

  logic signed [WW-1:0] v_w, u_w, a_w, i_w, vv_w, bv_w, sq, dv, bq, du, ud_w;
  logic signed [DW-1:0] v1, u1;

  assign st_in = nstate_t'(in_st);

  always_comb begin
    vv_n = st_in.v * st_in.v;
    bv_n = st_in.b * st_in.v;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) r_v <= 1'b0;
    else        r_v <= in_v;
  end

  always_ff @(posedge clk) begin
    if (in_v) begin
      r_idx <= in_idx;
      r_st  <= st_in;
      r_cur <= in_cur;
      r_vv  <= vv_n;
      r_bv  <= bv_n;
    end
  end

  always_comb begin
    v_w  = r_st.v;
    u_w  = r_st.u;
    a_w  = r_st.a;
    i_w  = r_cur;
    vv_w = r_vv;
    bv_w = r_bv;
    sq   = ((vv_w >>> FRAC) * K_SQ) >>> FRAC;
    dv   = sq + K_LIN * v_w + C_BIAS - u_w + i_w;
    v1   = sat_q(v_w + dv);
    bq   = bv_w >>> FRAC;
    du   = (a_w * (bq - u_w)) >>> FRAC;
    u1   = sat_q(u_w + du);
    ud_w = u1;
    wb_spike = (v1 >= V_PEAK);
    st_out   = r_st;
    if (wb_spike) begin
      st_out.v = r_st.c;
      st_out.u = sat_q(ud_w + WW'(r_st.d));
    end else begin
      st_out.v = v1;
      st_out.u = u1;
    end
  end

  assign wb_v   = r_v;
  assign wb_idx = r_idx;
  assign wb_st  = st_out;
endmodule

// File: rtl/neuron_step_engine.sv
module neuron_step_engine
  import ne_pkg::*;
#(
  parameter int NUM_NEURONS = 1024,
  parameter int FIFO_DEPTH  = 4,
  localparam int AW = (NUM_NEURONS > 1) ? $clog2(NUM_NEURONS) : 1,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic                 done,
  output logic                 st_rd_en,
  output logic [AW-1:0]        st_rd_addr,
  input  logic [SW-1:0]        st_rd_data,
  output logic                 st_wr_en,
  output logic [AW-1:0]        st_wr_addr,
  output logic [SW-1:0]        st_wr_data,
  output logic                 cur_rd_en,
  output logic [AW-1:0]        cur_rd_addr,
  input  logic [DW-1:0]        cur_rd_data,
  output logic                 cur_clr_en,
  output logic [AW-1:0]        cur_clr_addr,
  output logic                 spk_valid,
  input  logic                 spk_ready,
  output logic [AW-1:0]        spk_idx
);
  localparam logic [AW:0]   N_END = (AW + 1)'(NUM_NEURONS);
  localparam logic [AW-1:0] LAST  = AW'(NUM_NEURONS - 1);

  logic [1:0]    rsync;
  logic          rst_i;
  logic          busy, busy_n, done_n, issue;
  logic [AW:0]   cnt, cnt_n;
  logic          s1_v;
  logic [AW-1:0] s1_idx;
  logic          wb_v, wb_spike;
  logic [AW-1:0] wb_idx;
  logic [SW-1:0] wb_st;
  logic [CW-1:0] q_cnt;
  logic [CW:0]   occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_i = rsync[1];

  always_comb begin
    occ    = {1'b0, q_cnt} + (CW + 1)'(s1_v) + (CW + 1)'(wb_v);
    issue  = busy && (cnt < N_END) && (occ < (CW + 1)'(FIFO_DEPTH));
    busy_n = busy;
    cnt_n  = cnt;
    done_n = 1'b0;
    if (!busy && start) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end
    if (issue) cnt_n = cnt + 1'b1;
    if (wb_v && wb_idx == LAST) begin
      busy_n = 1'b0;
      done_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      busy   <= 1'b0;
      cnt    <= '0;
      done   <= 1'b0;
      s1_v   <= 1'b0;
      s1_idx <= '0;
    end else begin
      busy   <= busy_n;
      cnt    <= cnt_n;
      done   <= done_n;
      s1_v   <= issue;
      if (issue) s1_idx <= cnt[AW-1:0];
    end
  end

  assign st_rd_en     = issue;
  assign st_rd_addr   = cnt[AW-1:0];
  assign cur_rd_en    = issue;
  assign cur_rd_addr  = cnt[AW-1:0];
  assign cur_clr_en   = s1_v;
  assign cur_clr_addr = s1_idx;

  izh_update #(.AW(AW)) u_upd (
    .clk      (clk),
    .rst_i    (rst_i),
    .in_v     (s1_v),
    .in_idx   (s1_idx),
    .in_st    (st_rd_data),
    .in_cur   (cur_rd_data),
    .wb_v     (wb_v),
    .wb_idx   (wb_idx),
    .wb_st    (wb_st),
    .wb_spike (wb_spike)
  );

  assign st_wr_en   = wb_v;
  assign st_wr_addr = wb_idx;
  assign st_wr_data = wb_st;

  spike_queue #(.DEPTH(FIFO_DEPTH), .W(AW)) u_q (
    .clk       (clk),
    .rst_i     (rst_i),
    .push      (wb_v && wb_spike),
    .push_data (wb_idx),
    .out_valid (spk_valid),
    .out_ready (spk_ready),
    .out_data  (spk_idx),
    .count     (q_cnt)
  );

  // R2
  rd_order_chk: assert property (@(posedge clk) disable iff (!rst_i)
    st_rd_en && $past(st_rd_en) |-> st_rd_addr == $past(st_rd_addr) + 1'b1);

  // R9
  wb_order_chk: assert property (@(posedge clk) disable iff (!rst_i)
    st_wr_en && $past(st_wr_en) |-> st_wr_addr == $past(st_wr_addr) + 1'b1);

  // R6
  clr_follow_chk: assert property (@(posedge clk) disable iff (!rst_i)
    cur_clr_en |-> $past(cur_rd_en) && cur_clr_addr == $past(cur_rd_addr));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_i)
    done |=> !done);
endmodule

// File: tb/sim_neuron_step_engine.sv
module sim_neuron_step_engine;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = 3;
  localparam int SW = 96;

  // rows: v, u, a, b, c, d, I   (Q8.8)
  localparam logic signed [15:0] TV [N][7] = '{
    '{-16640, -3328,  5, 51, -16640, 2048,     0},
    '{-16640, -3328, 26, 64, -12800,  512,     0},
    '{     0,     0,  5, 51, -16640, 2048,     0},
    '{-17920, -3584,  5, 51, -16640, 2048,  1280},
    '{-10240, -2048,  5, 51, -12800,  512, 25600},
    '{-15360, -3072, 26, 64, -16640, 2048,  5120},
    '{  6400,     0,  5, 51, -16640, 2048,     0},
    '{-16640, -3328,  5, 51, -16640, 2048,     0}
  };
  localparam bit EXP_SPK [N] = '{0, 0, 1, 0, 1, 0, 1, 0};

  logic clk = 1'b0;
  logic rst_n, start, spk_ready;
  logic done, st_rd_en, st_wr_en, cur_rd_en, cur_clr_en, spk_valid;
  logic [AW-1:0] st_rd_addr, st_wr_addr, cur_rd_addr, cur_clr_addr, spk_idx;
  logic [SW-1:0] st_rd_data, st_wr_data;
  logic [15:0]   cur_rd_data;

  logic [SW-1:0] smem [N];
  logic [15:0]   cmem [N];

  int total = 0, bad = 0;
  int cyc = 0, start_cyc = -1, done_cyc = -1, done_cnt = 0;
  int nspk = 0, rd_next = 0, rd_bad = 0, cur_reads = 0;
  int wr_cnt [N];
  int spk_log [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  neuron_step_engine #(.NUM_NEURONS(N), .FIFO_DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .st_rd_en(st_rd_en), .st_rd_addr(st_rd_addr), .st_rd_data(st_rd_data),
    .st_wr_en(st_wr_en), .st_wr_addr(st_wr_addr), .st_wr_data(st_wr_data),
    .cur_rd_en(cur_rd_en), .cur_rd_addr(cur_rd_addr), .cur_rd_data(cur_rd_data),
    .cur_clr_en(cur_clr_en), .cur_clr_addr(cur_clr_addr),
    .spk_valid(spk_valid), .spk_ready(spk_ready), .spk_idx(spk_idx)
  );

  // memory models and monitors
  always @(posedge clk) begin
    if (st_rd_en) st_rd_data <= smem[st_rd_addr];
    if (st_wr_en) smem[st_wr_addr] <= st_wr_data;
    if (cur_rd_en) cur_rd_data <= cmem[cur_rd_addr];
    if (cur_clr_en) cmem[cur_clr_addr] <= 16'h0;
    if (st_rd_en) begin
      if (int'(st_rd_addr) != rd_next) rd_bad++;
      rd_next++;
    end
    if (cur_rd_en) cur_reads++;
    if (st_wr_en) wr_cnt[st_wr_addr]++;
    if (spk_valid && spk_ready && nspk < 64) begin
      spk_log[nspk] = int'(spk_idx);
      nspk++;
    end
    if (start && start_cyc < 0) start_cyc = cyc;
    if (done) begin
      done_cnt++;
      done_cyc = cyc;
    end
    cyc++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  // expected update per R3, R4, R5
  function automatic void model(input logic [SW-1:0] s, input logic signed [15:0] cur,
                                output logic [SW-1:0] o, output bit fire);
    longint v, u, a, b, c, d, vn, un;
    v = longint'($signed(s[15:0]));  u = longint'($signed(s[31:16]));
    a = longint'($signed(s[47:32])); b = longint'($signed(s[63:48]));
    c = longint'($signed(s[79:64])); d = longint'($signed(s[95:80]));
    vn = sat(v + ((((v * v) >>> 8) * 10) >>> 8) + 5 * v + 35840 - u + longint'(cur));
    un = sat(u + ((a * (((b * v) >>> 8) - u)) >>> 8));
    fire = (vn >= 7680);
    if (fire) begin
      vn = c;
      un = sat(un + d);
    end
    o = s;
    o[15:0]  = 16'(vn);
    o[31:16] = 16'(un);
  endfunction

  logic [SW-1:0] exp_st [N];
  bit exp_fire [N];

  task automatic prepare();
    for (int i = 0; i < N; i++) begin
      bit f;
      model(smem[i], $signed(cmem[i]), exp_st[i], f);
      exp_fire[i] = f;
      wr_cnt[i] = 0;
    end
    nspk = 0; rd_next = 0; rd_bad = 0; cur_reads = 0;
    start_cyc = -1; done_cyc = -1; done_cnt = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 400 && done_cnt == 0; k++) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic verify_pass(input string tag);
    int e;
    for (int i = 0; i < N; i++) begin
      chk(smem[i][15:0] == exp_st[i][15:0], "R3 R5 v", $signed(smem[i][15:0]), $signed(exp_st[i][15:0]));
      chk(smem[i][31:16] == exp_st[i][31:16], "R4 R5 u", $signed(smem[i][31:16]), $signed(exp_st[i][31:16]));
      chk(wr_cnt[i] == 1, "R9 one write", wr_cnt[i], 1);
      chk(cmem[i] == 16'h0, "R6 cleared", cmem[i], 0);
    end
    chk(rd_bad == 0 && rd_next == N, "R2 read order", rd_next, N);
    chk(cur_reads == N, "R6 single read", cur_reads, N);
    chk(done_cnt == 1, "R8 one done", done_cnt, 1);
    e = 0;
    for (int i = 0; i < N; i++) if (exp_fire[i]) begin
      chk(e < nspk && spk_log[e] == i, "R7 spike order", (e < nspk) ? spk_log[e] : -1, i);
      e++;
    end
    chk(nspk == e, "R7 spike count", nspk, e);
    $display("pass %s checked", tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; spk_ready = 1'b1;
    for (int i = 0; i < N; i++) begin
      smem[i] = {TV[i][5], TV[i][4], TV[i][3], TV[i][2], TV[i][1], TV[i][0]};
      cmem[i] = TV[i][6];
    end
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!done && !spk_valid && !st_rd_en && !st_wr_en && !cur_rd_en && !cur_clr_en,
        "R1 reset idle", {done, spk_valid, st_rd_en, st_wr_en}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!done && !spk_valid && !st_rd_en && !st_wr_en && !cur_clr_en,
        "R1 idle after reset", {done, spk_valid, st_rd_en, st_wr_en}, 0);

    // pass 1: table vectors, no backpressure
    prepare();
    for (int i = 0; i < N; i++)
      chk(exp_fire[i] == EXP_SPK[i], "R5 table fire flag", exp_fire[i], EXP_SPK[i]);
    pulse_start();
    wait_done();
    chk(done_cyc - start_cyc == N + 3, "R8 done latency", done_cyc - start_cyc, N + 3);
    verify_pass("table");

    // pass 2: every neuron driven hard, stream stalled -> throttling
    for (int i = 0; i < N; i++) cmem[i] = 16'sd32000;
    prepare();
    spk_ready = 1'b0;
    pulse_start();
    repeat (25) @(negedge clk);
    begin
      logic [AW-1:0] held;
      held = spk_idx;
      chk(spk_valid, "R7 valid during stall", spk_valid, 1);
      chk(done_cnt == 0, "R7 admission throttled", done_cnt, 0);
      repeat (10) @(negedge clk);
      chk(spk_valid && spk_idx == held, "R7 held while stalled", spk_idx, held);
      chk(nspk == 0, "R7 nothing taken while stalled", nspk, 0);
    end
    spk_ready = 1'b1;
    wait_done();
    verify_pass("stalled");

    // pass 3: second start during the pass is ignored
    for (int i = 0; i < N; i++) cmem[i] = 16'h0;
    prepare();
    pulse_start();
    repeat (2) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    repeat (N + 6) @(negedge clk);
    chk(done_cnt == 1, "R2 start while busy ignored", done_cnt, 1);
    verify_pass("restart");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule